// File: doc/BRIEF.md
# Load-dependent valley count regulator

This block keeps the number of ringing valleys that a quasi-resonant flyback controller lets pass before it turns the power switch on again. Light load calls for more skipped valleys, which lowers the switching frequency. Heavy load calls for fewer. The count changes slowly: it moves by at most one step per slow periodic tick, in the direction set by the load band of the regulation voltage. Three threshold comparators, which sit outside this block, report that band as flags.

Two events bypass the slow path. If the regulation voltage goes above the top threshold, a request is stored and the count falls to 1 at the next switching-period strobe. If the burst controller reports that burst operation has ended, the count falls to 1 on the next clock. The downstream valley comparator uses the 3-bit count without further processing.

Top module: `valley_skip_regulator`

## Requirements
- R1: After reset the count output is 1 and no force-to-one request is pending.
- R2: The count output is never below 1 and never above 7.
- R3: On a tick, with no flag asserted (voltage below the low threshold), the count rises by one. At 7 it stays at 7.
- R4: On a tick, with only `lvl_lo` asserted (voltage between the low and high thresholds), the count keeps its value.
- R5: On a tick, with `lvl_hi` asserted and `lvl_top` deasserted, the count falls by one. At 1 it stays at 1.
- R6: In a cycle with no tick, no period strobe and no burst exit, the count does not change.
- R7: In any cycle with `lvl_top` asserted, a force-to-one request is stored and a tick does not step the count. The count becomes 1 on the clock edge of the first `period_stb` at or after that cycle, and no earlier.
- R8: `burst_exit` sets the count to 1 on the next clock edge, whatever the other inputs are. It also drops a stored request unless `lvl_top` is asserted in the same cycle.
- R9: A stored request is used up by one `period_stb`. Later strobes with `lvl_top` low leave the count unchanged. If a strobe and a tick fall in the same cycle, the pending force wins.
- R10: The band is taken from the highest asserted flag, in the priority order `lvl_top`, `lvl_hi`, `lvl_lo`. For example, `lvl_hi` without `lvl_lo` still counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the slow periodic update clock |
| period_stb | input | 1 | One-cycle pulse at the start of each switching period |
| burst_exit | input | 1 | One-cycle pulse when burst operation ends |
| lvl_lo | input | 1 | Regulation voltage above the low threshold |
| lvl_hi | input | 1 | Regulation voltage above the high threshold |
| lvl_top | input | 1 | Regulation voltage above the top (force) threshold |
| skip_cnt | output | 3 | Number of valleys to skip, from 1 to 7 |

## Verification
The bench drives the count into both rails with extra ticks. A design with an off-by-one limit would wrap to 0 or rise to 8, and the per-clock compare with the reference model catches that. It raises `lvl_top` for a single cycle, then waits for many cycles and several ticks before the strobe arrives. A design that forced the count early would drop it too soon, and one that did not latch the request would never drop it. It then sends extra strobes to catch a request that is never cleared. Other cases are strobe and tick in the same cycle, burst exit at the same time as a pending request, and flag combinations that are not thermometer-coded. A design with the wrong priority or band decoding would move the count in the wrong direction.

// File: rtl/vsr_pkg.sv
`timescale 1ns/1ps
package vsr_pkg;
  // load band of the regulation voltage, ordered by rising voltage
  typedef enum logic [1:0] {
    BAND_RISE  = 2'd0,
    BAND_KEEP  = 2'd1,
    BAND_FALL  = 2'd2,
    BAND_FORCE = 2'd3
  } vsr_band_e;
endpackage

// File: rtl/vsr_band_decode.sv
`timescale 1ns/1ps
module vsr_band_decode
  import vsr_pkg::*;
(
  input  logic      lvl_lo,
  input  logic      lvl_hi,
  input  logic      lvl_top,
  output vsr_band_e band
);
  // highest asserted flag wins (R10)
  always_comb begin
    if (lvl_top)     band = BAND_FORCE;
    else if (lvl_hi) band = BAND_FALL;
    else if (lvl_lo) band = BAND_KEEP;
    else             band = BAND_RISE;
  end
endmodule

// File: rtl/vsr_force_latch.sv
`timescale 1ns/1ps
module vsr_force_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic period_stb,
  input  logic burst_exit,
  output logic apply
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = req_set | (pend_q & ~period_stb & ~burst_exit);
    apply  = period_stb & (pend_q | req_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> pend_q);
  assert_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && !req_set) |=> !pend_q);
endmodule

// File: rtl/vsr_step.sv
`timescale 1ns/1ps
module vsr_step
  import vsr_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int CNT_MIN = 1,
  parameter int CNT_MAX = 7
) (
  input  logic [CNT_W-1:0] cur,
  input  vsr_band_e        band,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);

  always_comb begin
    nxt = cur;
    case (band)
      BAND_RISE: if (cur < MAX_V) nxt = cur + 1'b1;
      BAND_FALL: if (cur > MIN_V) nxt = cur - 1'b1;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/valley_skip_regulator.sv
`timescale 1ns/1ps
module valley_skip_regulator
  import vsr_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int CNT_MIN = 1,
  parameter int CNT_MAX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             period_stb,
  input  logic             burst_exit,
  input  logic             lvl_lo,
  input  logic             lvl_hi,
  input  logic             lvl_top,
  output logic [CNT_W-1:0] skip_cnt
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);

  vsr_band_e        band;
  logic             force_req;
  logic             apply;
  logic [CNT_W-1:0] stepped;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  vsr_band_decode u_dec (
    .lvl_lo (lvl_lo),
    .lvl_hi (lvl_hi),
    .lvl_top(lvl_top),
    .band   (band)
  );

  assign force_req = (band == BAND_FORCE);

  vsr_force_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_set   (force_req),
    .period_stb(period_stb),
    .burst_exit(burst_exit),
    .apply     (apply)
  );

  vsr_step #(.CNT_W(CNT_W), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX)) u_step (
    .cur (cnt_q),
    .band(band),
    .nxt (stepped)
  );

  // next state: burst exit and strobe force beat the slow step
  always_comb begin
    cnt_en = burst_exit | apply | tick;
    if (burst_exit || apply) cnt_d = MIN_V;
    else if (tick)           cnt_d = stepped;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= MIN_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign skip_cnt = cnt_q;

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_cnt >= MIN_V) && (skip_cnt <= MAX_V));
  assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lvl_lo && !lvl_hi && !lvl_top && !burst_exit && !period_stb && skip_cnt < MAX_V)
    |=> skip_cnt == $past(skip_cnt) + 1'b1);
  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lvl_lo && !lvl_hi && !lvl_top && !burst_exit && !period_stb) |=> $stable(skip_cnt));
  assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lvl_hi && !lvl_top && !burst_exit && !period_stb && skip_cnt > MIN_V)
    |=> skip_cnt == $past(skip_cnt) - 1'b1);
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !period_stb && !burst_exit) |=> $stable(skip_cnt));
  assert_nostep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_top && !period_stb && !burst_exit) |=> $stable(skip_cnt));
  assert_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_exit |=> skip_cnt == MIN_V);
endmodule

// File: tb/valley_skip_regulator_test.sv
`timescale 1ns/1ps
module valley_skip_regulator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, period_stb = 1'b0, burst_exit = 1'b0;
  logic       lvl_lo = 1'b0, lvl_hi = 1'b0, lvl_top = 1'b0;
  logic [2:0] skip_cnt;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  string req      = "R1";

  // reference model state
  int ref_cnt = 1;
  bit ref_pend = 0;

  always #5 clk = ~clk;

  valley_skip_regulator uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_stb(period_stb),
    .burst_exit(burst_exit), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi),
    .lvl_top(lvl_top), .skip_cnt(skip_cnt)
  );

  // behavioural reference built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  = 1;
      ref_pend = 0;
    end else begin
      int band;
      bit old_pend;
      band = lvl_top ? 3 : lvl_hi ? 2 : lvl_lo ? 1 : 0;  // R10
      old_pend = ref_pend;
      if (burst_exit) ref_cnt = 1;                        // R8
      else if (period_stb && (old_pend || lvl_top)) ref_cnt = 1;  // R7 R9
      else if (tick) begin
        if (band == 0 && ref_cnt < 7) ref_cnt = ref_cnt + 1;      // R3
        else if (band == 2 && ref_cnt > 1) ref_cnt = ref_cnt - 1; // R5
      end
      ref_pend = lvl_top || (old_pend && !period_stb && !burst_exit);
    end
  end

  task automatic check(input int exp_v, input string r);
    n_checks++;
    if (int'(skip_cnt) != exp_v) begin
      n_fails++;
      $display("FAIL %s: skip_cnt=%0d expected=%0d at %0t", r, skip_cnt, exp_v, $time);
    end
  endtask

  // compare against the model, then drive the next inputs
  task automatic cyc(input bit t, input bit s, input bit b, input bit lo, input bit hi, input bit top);
    @(negedge clk);
    check(ref_cnt, req);
    tick = t; period_stb = s; burst_exit = b;
    lvl_lo = lo; lvl_hi = hi; lvl_top = top;
  endtask

  task automatic idle(input int n, input bit lo, input bit hi, input bit top);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, lo, hi, top);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1"; check(1, "R1");
    idle(2, 0, 0, 0);

    req = "R3";  // climb past the top rail
    for (int i = 0; i < 9; i++) begin cyc(1, 0, 0, 0, 0, 0); idle(2, 0, 0, 0); end
    @(negedge clk); check(7, "R3"); check(7, "R2");

    req = "R4";
    for (int i = 0; i < 3; i++) begin cyc(1, 0, 0, 1, 0, 0); idle(2, 1, 0, 0); end
    @(negedge clk); check(7, "R4");

    req = "R5";  // descend past the bottom rail
    for (int i = 0; i < 9; i++) begin cyc(1, 0, 0, 1, 1, 0); idle(2, 1, 1, 0); end
    @(negedge clk); check(1, "R5"); check(1, "R2");

    req = "R10";  // high flag without low flag still falls
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0); idle(2, 0, 0, 0);
    @(negedge clk); check(4, "R10");

    req = "R6";
    idle(20, 0, 0, 0);
    @(negedge clk); check(4, "R6");

    req = "R7";  // one-cycle top request, tick during top, then delay
    cyc(1, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 0);
    @(negedge clk); check(4, "R7");
    idle(10, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0); idle(3, 0, 0, 0);
    @(negedge clk); check(5, "R7");
    cyc(0, 1, 0, 0, 0, 0); idle(1, 0, 0, 0);
    @(negedge clk); check(1, "R7");

    req = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0); idle(2, 0, 0, 0);
    @(negedge clk); check(4, "R9");
    cyc(0, 0, 0, 1, 1, 1); cyc(1, 1, 0, 0, 0, 0); idle(1, 0, 0, 0);
    @(negedge clk); check(1, "R9");
    cyc(0, 1, 1, 1, 1, 1); cyc(0, 0, 0, 0, 0, 0);  // strobe consumes while top high re-arms
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0); idle(1, 0, 0, 0);
    @(negedge clk); check(1, "R9");

    req = "R8";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0); idle(1, 0, 0, 0);
    @(negedge clk); check(1, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 1); cyc(0, 0, 1, 0, 0, 0);  // burst drops pending request
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0); idle(2, 0, 0, 0);
    @(negedge clk); check(3, "R8");

    req = "R2";
    idle(4, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog (%s): skip_cnt=%0d expected=finish", req, skip_cnt);
      summary();
      $finish;
    end
  end
endmodule